// File: doc/BRIEF.md
# Reed-Solomon Symbol Correction Applier

This block takes symbol corrections that an upstream decoder has already located for one flash page. The page holds 2048 data bytes followed by 64 spare bytes. It is protected by a Reed-Solomon code over 12-bit symbols. Two symbols are packed into every three bytes, so a symbol usually straddles a byte boundary. Symbol 0 is the exception: it holds only eight real bits.

Each correction arrives as a (position, 12-bit pattern) pair on a valid/ready stream, with a flag that marks the page's last pair. For each pair the block works out which one or two buffer bytes the symbol covers. It then XORs the matching part of the pattern into each byte with a read-modify-write over a byte-wide buffer port. The buffer addresses are linear: spare byte k sits at address 2048+k. When a position cannot be corrected, or when the page has too many pairs, the block raises a sticky fail flag and makes no further buffer writes for that page. After the last pair it pulses `done` together with the count of symbols it corrected.

The controller is a state machine with six states:
- `ST_IDLE` waits for a pair.
- `ST_RD_A` and `ST_WR_A` read and write the first byte.
- `ST_RD_B` and `ST_WR_B` read and write the second byte.
- `ST_DONE` reports the page result.

Transitions:
- From IDLE, an accepted good pair goes to RD_A.
- From IDLE, a rejected pair stays in IDLE, or goes to DONE if it is the last pair.
- RD_A always goes to WR_A, and RD_B always goes to WR_B.
- WR_A goes to RD_B for a two-byte symbol. Otherwise it finishes the pair.
- WR_B finishes the pair.
- Finishing a pair goes to DONE if the pair was the last one, and to IDLE otherwise.
- DONE always returns to IDLE.

Top module: `sym_patch_engine`

## Requirements
- R1: For an odd position p up to 1365, byte floor(3p/2) is XORed with pattern bits 11..4, and byte floor(3p/2)+1 is XORed with pattern bits 3..0 placed in bits 7..4.
- R2: For an even position p from 2 up to 1364, byte 3p/2-1 is XORed with pattern bits 11..8 (in bits 3..0), and byte 3p/2 is XORed with pattern bits 7..0.
- R3: Position 0 with a pattern no greater than 0xFF XORs byte 0 with pattern bits 7..0 and touches no other byte.
- R4: Position 1365 updates data byte 2047 with pattern bits 11..4, and spare byte 0 (address 2048) with pattern bits 3..0 in bits 7..4.
- R5: Positions 1366 to 1374 follow the odd/even rules of R1 and R2 on the linear address, so they land in the spare area at addresses 2048 to 2061. The block never addresses a byte at 2112 or above.
- R6: A position above 1374 makes the page fail.
- R7: Position 0 with a pattern above 0xFF makes the page fail.
- R8: A fifth pair in one page makes the page fail. `fix_count` never exceeds 4.
- R9: Once `page_fail` is set, no buffer write occurs for the rest of the page. Later pairs are accepted and discarded until the last one, and `page_fail` stays high until `done`.
- R10: Each byte update is a read in one cycle (`mem_rdata` valid in the next cycle) followed by a write to the same address in the next cycle. For a two-byte symbol, the lower address is updated first.
- R11: `in_ready` is high only in the idle state, and pairs are applied strictly in arrival order.
- R12: `done` is a one-cycle pulse in the cycle after the last pair's final write, or in the cycle after a rejected last pair is accepted. `fix_count` and `page_fail` are valid with it and clear after it.
- R13: After reset, `in_ready` is 1 and `done`, `page_fail`, `mem_rd_en` and `mem_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Correction pair valid |
| in_ready | output | 1 | Block can accept a pair |
| in_pos | input | 11 | Symbol position |
| in_pat | input | 12 | Error pattern |
| in_last | input | 1 | Pair is the page's last |
| mem_addr | output | 12 | Buffer byte address |
| mem_rd_en | output | 1 | Buffer read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Buffer write data |
| done | output | 1 | Page finished pulse |
| fix_count | output | 3 | Symbols corrected in the page |
| page_fail | output | 1 | Page is uncorrectable |

## Verification
The assertions check, on every cycle, the shape of the buffer traffic:
- every write follows a read of the same address in the cycle before;
- no write happens while `page_fail` is high;
- addresses stay inside the 2112-byte buffer;
- `done` is a single-cycle pulse;
- `fix_count` stays within its cap.

Only the bench scenarios can show that the correct bytes receive the correct pattern bits. These scenarios cover odd and even symbols, symbol 0, the data/spare boundary and the spare-area tail. They also show that rejected pairs leave the whole buffer untouched and that the reported count matches the pairs applied before a failure.

// File: rtl/sym_patch_pkg.sv
package sym_patch_pkg;

    localparam int DATA_BYTES  = 2048;
    localparam int SPARE_BYTES = 64;
    localparam int BUF_BYTES   = DATA_BYTES + SPARE_BYTES;
    localparam int ADDR_W      = $clog2(BUF_BYTES);
    localparam int SYM_W       = 12;
    localparam int POS_W       = 11;
    localparam int LAST_POS    = 1374;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_WR_A,
        ST_RD_B,
        ST_WR_B,
        ST_DONE
    } patch_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr_a;
        logic [ADDR_W-1:0] addr_b;
        logic [7:0]        mask_a;
        logic [7:0]        mask_b;
        logic              two_bytes;
        logic              bad;
    } byte_plan_t;

endpackage

// File: rtl/sym_patch_map.sv
module sym_patch_map
    import sym_patch_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  logic [SYM_W-1:0] pat,
    output byte_plan_t       plan
);
    localparam int TRIP_W = POS_W + 2;

    logic [TRIP_W-1:0] trip;
    logic [ADDR_W-1:0] half;
    logic              out_of_range;
    logic              zero_pos;

    always_comb begin
        trip         = {2'b00, pos} + {1'b0, pos, 1'b0};
        half         = trip[ADDR_W:1];
        out_of_range = (pos > POS_W'(LAST_POS));
        zero_pos     = (pos == '0);

        plan.bad       = out_of_range || (zero_pos && (pat[11:8] != 4'h0));
        plan.two_bytes = 1'b1;
        plan.addr_a    = half;
        plan.addr_b    = half + ADDR_W'(1);
        plan.mask_a    = pat[11:4];
        plan.mask_b    = {pat[3:0], 4'h0};

        if (zero_pos) begin
            plan.two_bytes = 1'b0;
            plan.addr_a    = '0;
            plan.mask_a    = pat[7:0];
        end else if (!pos[0]) begin
            plan.addr_a = half - ADDR_W'(1);
            plan.addr_b = half;
            plan.mask_a = {4'h0, pat[11:8]};
            plan.mask_b = pat[7:0];
        end
    end
endmodule

// File: rtl/sym_patch_fsm.sv
module sym_patch_fsm
    import sym_patch_pkg::*;
#(
    parameter int MAX_FIX = 4,
    localparam int CNT_W  = $clog2(MAX_FIX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  byte_plan_t        plan,
    output logic              in_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata,
    output logic              done,
    output logic [CNT_W-1:0]  fix_count,
    output logic              page_fail
);
    patch_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_a_q, addr_b_q;
    logic [7:0]        mask_a_q, mask_b_q;
    logic              two_q, last_q, fail_q;
    logic [CNT_W-1:0]  count_q;
    logic              accept, reject, pair_end;

    assign accept   = (state_q == ST_IDLE) && in_valid;
    assign reject   = fail_q || plan.bad || (count_q == CNT_W'(MAX_FIX));
    assign pair_end = (state_q == ST_WR_B) || ((state_q == ST_WR_A) && !two_q);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    if (reject) state_d = in_last ? ST_DONE : ST_IDLE;
                    else        state_d = ST_RD_A;
                end
            end
            ST_RD_A: state_d = ST_WR_A;
            ST_WR_A: begin
                if (two_q)       state_d = ST_RD_B;
                else if (last_q) state_d = ST_DONE;
                else             state_d = ST_IDLE;
            end
            ST_RD_B: state_d = ST_WR_B;
            ST_WR_B: state_d = last_q ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pair and page bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_a_q <= '0;
            addr_b_q <= '0;
            mask_a_q <= '0;
            mask_b_q <= '0;
            two_q    <= 1'b0;
            last_q   <= 1'b0;
            fail_q   <= 1'b0;
            count_q  <= '0;
        end else begin
            if (accept) begin
                last_q <= in_last;
                if (reject) begin
                    fail_q <= 1'b1;
                end else begin
                    addr_a_q <= plan.addr_a;
                    addr_b_q <= plan.addr_b;
                    mask_a_q <= plan.mask_a;
                    mask_b_q <= plan.mask_b;
                    two_q    <= plan.two_bytes;
                end
            end
            if (pair_end) count_q <= count_q + CNT_W'(1);
            if (state_q == ST_DONE) begin
                count_q <= '0;
                fail_q  <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = addr_a_q;
        mem_wdata = mem_rdata ^ mask_a_q;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready = 1'b1;
            ST_RD_A: mem_rd_en = 1'b1;
            ST_WR_A: mem_wr_en = 1'b1;
            ST_RD_B: begin
                mem_rd_en = 1'b1;
                mem_addr  = addr_b_q;
            end
            ST_WR_B: begin
                mem_wr_en = 1'b1;
                mem_addr  = addr_b_q;
                mem_wdata = mem_rdata ^ mask_b_q;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign fix_count = count_q;
    assign page_fail = fail_q;
endmodule

// File: rtl/sym_patch_engine.sv
module sym_patch_engine
    import sym_patch_pkg::*;
#(
    parameter int MAX_FIX = 4,
    localparam int CNT_W  = $clog2(MAX_FIX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [POS_W-1:0]  in_pos,
    input  logic [SYM_W-1:0]  in_pat,
    input  logic              in_last,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata,
    output logic              done,
    output logic [CNT_W-1:0]  fix_count,
    output logic              page_fail
);
    byte_plan_t plan;

    sym_patch_map u_map (
        .pos  (in_pos),
        .pat  (in_pat),
        .plan (plan)
    );

    sym_patch_fsm #(.MAX_FIX(MAX_FIX)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .plan      (plan),
        .in_ready  (in_ready),
        .mem_addr  (mem_addr),
        .mem_rd_en (mem_rd_en),
        .mem_rdata (mem_rdata),
        .mem_wr_en (mem_wr_en),
        .mem_wdata (mem_wdata),
        .done      (done),
        .fix_count (fix_count),
        .page_fail (page_fail)
    );
endmodule

// File: rtl/sym_patch_chk.sv
module sym_patch_chk
    import sym_patch_pkg::*;
#(
    parameter int MAX_FIX = 4,
    localparam int CNT_W  = $clog2(MAX_FIX + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic              done,
    input logic [CNT_W-1:0]  fix_count,
    input logic              page_fail
);
    assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    assert_wr_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && (mem_addr == $past(mem_addr))));

    assert_rd_then_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en);

    assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> (mem_addr < ADDR_W'(BUF_BYTES)));

    assert_no_wr_on_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        page_fail |-> !mem_wr_en);

    assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (page_fail && !done) |=> page_fail);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!mem_rd_en && !mem_wr_en && !done));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_count_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fix_count <= CNT_W'(MAX_FIX));
endmodule

bind sym_patch_engine sym_patch_chk #(.MAX_FIX(MAX_FIX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .done      (done),
    .fix_count (fix_count),
    .page_fail (page_fail)
);

// File: tb/sym_patch_engine_tb.sv
module sym_patch_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 2112;
    localparam int NV         = 20;

    // table: position, pattern, last flag, page tag
    localparam logic [10:0] V_POS [NV] = '{
        11'd1, 11'd2, 11'd1365, 11'd0,
        11'd1366, 11'd1367, 11'd1374,
        11'd5, 11'd1375, 11'd7,
        11'd0,
        11'd10, 11'd11, 11'd12, 11'd13, 11'd14,
        11'd1364, 11'd683,
        11'd0, 11'd2047};
    localparam logic [11:0] V_PAT [NV] = '{
        12'hABC, 12'h5A3, 12'hF0F, 12'h0C5,
        12'h123, 12'h9A1, 12'hFFF,
        12'h111, 12'h222, 12'h333,
        12'h1FF,
        12'h101, 12'h202, 12'h303, 12'h404, 12'h505,
        12'h0F0, 12'h7E7,
        12'h0FF, 12'h456};
    localparam logic V_LAST [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b1,
        1'b0, 1'b0, 1'b1,
        1'b0, 1'b0, 1'b1,
        1'b1,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
        1'b0, 1'b1,
        1'b0, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [10:0] in_pos = '0;
    logic [11:0] in_pat = '0;
    logic        in_last = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rdata;
    logic        mem_wr_en;
    logic [7:0]  mem_wdata;
    logic        done;
    logic [2:0]  fix_count;
    logic        page_fail;

    logic [7:0]  mem  [NBYTES];
    logic [7:0]  gold [NBYTES];

    int n_checks = 0;
    int n_fails  = 0;
    int exp_cnt  = 0;
    bit exp_fail = 1'b0;
    int page_no  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sym_patch_engine u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pos(in_pos), .in_pat(in_pat), .in_last(in_last),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .done(done),
        .fix_count(fix_count), .page_fail(page_fail));

    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected effect of one pair, straight from the requirements
    task automatic model(input int p, input int pat);
        if (exp_fail) return;
        if (p > 1374 || (p == 0 && pat > 255) || exp_cnt == 4) begin
            exp_fail = 1'b1;
            return;
        end
        if (p == 0) begin
            gold[0] ^= 8'(pat);
        end else if (p % 2 == 1) begin
            gold[(3*p)/2]     ^= 8'(pat >> 4);
            gold[(3*p)/2 + 1] ^= 8'((pat & 15) << 4);
        end else begin
            gold[(3*p)/2 - 1] ^= 8'(pat >> 8);
            gold[(3*p)/2]     ^= 8'(pat & 255);
        end
        exp_cnt++;
    endtask

    task automatic send(input int p, input int pat, input bit last);
        in_pos   = 11'(p);
        in_pat   = 12'(pat);
        in_last  = last;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_page(input string req);
        int k = 0;
        int bad = 0;
        while (!done && k < 50) begin
            @(negedge clk);
            k++;
        end
        check("R12", "done seen", int'(done), 1);
        check(req, "fix_count", int'(fix_count), exp_cnt);
        check(req, "page_fail", int'(page_fail), int'(exp_fail));
        for (int i = 0; i < NBYTES; i++) if (mem[i] !== gold[i]) bad++;
        check(req, "buffer mismatches", bad, 0);
        @(negedge clk);
        check("R12", "done cleared", int'(done), 0);
        exp_cnt  = 0;
        exp_fail = 1'b0;
        page_no++;
    endtask

    function automatic string page_tag(input int n);
        case (n)
            0: return "R1";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            5: return "R2";
            6: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NBYTES; i++) begin
            mem[i]  = 8'((i * 7 + 3) & 255);
            gold[i] = 8'((i * 7 + 3) & 255);
        end
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13", "in_ready", int'(in_ready), 1);
        check("R13", "done", int'(done), 0);
        check("R13", "page_fail", int'(page_fail), 0);
        check("R13", "mem strobes", int'({mem_rd_en, mem_wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk; page tags: R1 mixed/boundary R4, R5 spare, R6 range,
        // R7 zero overflow, R8 fifth pair, R2 even near boundary, R3 zero ok
        for (int i = 0; i < NV; i++) begin
            model(int'(V_POS[i]), int'(V_PAT[i]));
            send(int'(V_POS[i]), int'(V_PAT[i]), V_LAST[i]);
            if (V_LAST[i]) finish_page(page_tag(page_no));
        end

        // R10 / R11 directed timing: odd position 3 covers bytes 4 and 5
        model(3, 12'h6B4);
        send(3, 12'h6B4, 1'b1);
        check("R10", "rd strobe A", int'(mem_rd_en), 1);
        check("R10", "addr A", int'(mem_addr), 4);
        check("R11", "not ready while busy", int'(in_ready), 0);
        @(negedge clk);
        check("R10", "wr strobe A", int'(mem_wr_en), 1);
        check("R10", "addr A write", int'(mem_addr), 4);
        check("R10", "wdata A", int'(mem_wdata), int'(gold[4]));
        @(negedge clk);
        check("R10", "rd addr B", int'(mem_addr) + 16'h100 * int'(mem_rd_en), 16'h105);
        @(negedge clk);
        check("R10", "wdata B", int'(mem_wdata), int'(gold[5]));
        @(negedge clk);
        check("R12", "done one cycle after last write", int'(done), 1);
        finish_page("R10");

        // R9: rejected first pair, later good pairs are discarded
        model(1400, 12'h001);
        send(1400, 12'h001, 1'b0);
        check("R9", "fail raised early", int'(page_fail), 1);
        model(9, 12'hFFF);
        send(9, 12'hFFF, 1'b0);
        check("R9", "no read after fail", int'(mem_rd_en), 0);
        model(4, 12'hFFF);
        send(4, 12'hFFF, 1'b1);
        finish_page("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule